// File: doc/BRIEF.md
# Latched-Address Static RAM Controller

This block is a 64-word, 4-bit read/write memory driven by two active-low strobes: a memory enable and a write enable. The block does not sample the strobes asynchronously. Each strobe passes through a two-flop synchroniser onto the system clock, and an edge detector follows it. Every state change happens on the system clock.

When the memory enable falls, the block loads the address inputs into an internal register. That register selects the word for the rest of the access, so the address bus may change freely until the next falling edge. While the access is open and write enable is high, the block drives the selected word with an output-enable flag, and reading does not change the memory.

A write enable pulse inside an open access commits the data inputs to the held location when write enable rises. A pulse shorter than `MIN_WE_CYCLES` clocks writes nothing and sets a sticky error flag. Both writing and being disabled lower the output-enable flag, which models a high-impedance output.

Top module: `latram_ctrl`

## Requirements
- R1: After reset, `dout_oe` is 0, `dout` is 0 and `pulse_err` is 0.
- R2: The address inputs are captured at the synchronised falling edge of `mem_en_n`. Later changes on `addr_in` during the same access have no effect on the word read or written.
- R3: Suppose `mem_en_n` goes low with `wr_en_n` high. Then, from the fourth rising clock edge after the falling edge is first sampled, `dout_oe` is 1 and `dout` shows the word at the captured address.
- R4: Reads are nondestructive: reading the same location in two separate accesses returns the same word.
- R5: A write enable low pulse of at least `MIN_WE_CYCLES` clocks inside an open access writes `din` to the captured location. `din` is sampled at the synchronised rising edge of `wr_en_n`.
- R6: While `wr_en_n` is low inside an open access, `dout_oe` is 0.
- R7: While `mem_en_n` is high, `dout_oe` is 0 and `dout` is 0.
- R8: A write enable low pulse shorter than `MIN_WE_CYCLES` clocks writes nothing and sets `pulse_err`. The flag stays 1 until reset.
- R9: A pulse of exactly `MIN_WE_CYCLES` clocks (default 3) is accepted as a write.
- R10: Reset does not clear the memory contents.
- R11: After a write completes, the output in the same access shows the newly written word once `wr_en_n` is high again.
- R12: A `wr_en_n` pulse while `mem_en_n` is high writes nothing and does not set `pulse_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_en_n | input | 1 | Active-low memory enable strobe; its falling edge captures the address |
| wr_en_n | input | 1 | Active-low write strobe; its rising edge commits data |
| addr_in | input | 6 | Word address, captured on the enable falling edge |
| din | input | 4 | Write data, sampled when the write strobe rises |
| dout | output | 4 | Read data, 0 while not driven |
| dout_oe | output | 1 | High while the output is driven; low models high impedance |
| pulse_err | output | 1 | Sticky flag for a write pulse that was too short |

## Verification
The hardest case to reach from the ports is the pulse-width boundary. The pulse length the counter sees depends on where the strobe edges fall relative to the synchroniser. The bench drives `wr_en_n` only on falling clock edges, so a pulse held for N negedge-to-negedge intervals covers exactly N rising edges. The bench then tries one pulse a clock short of the limit and one exactly at it, and observes each result by reading the location back.

// File: rtl/latram_pkg.sv
package latram_pkg;
  // Synchronised strobe and its one-cycle edge pulses
  typedef struct packed {
    logic lvl_n;
    logic fall;
    logic rise;
  } strobe_t;
endpackage

// File: rtl/latram_rst_sync.sv
module latram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/latram_strobe.sv
module latram_strobe
  import latram_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pin_n,
  output strobe_t strobe
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= pin_n;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    strobe.lvl_n = sync_q;
    strobe.fall  = prev_q & ~sync_q;
    strobe.rise  = ~prev_q & sync_q;
  end
endmodule

// File: rtl/latram_store.sv
module latram_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage is deliberately not reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data))); // R5
endmodule

// File: rtl/latram_wctl.sv
module latram_wctl
  import latram_pkg::*;
#(
  parameter int MIN_WE_CYCLES = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  strobe_t we,
  output logic    wr_go,
  output logic    err
);
  localparam int CW = $clog2(MIN_WE_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_WE_CYCLES);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          long_enough;

  assign long_enough = (cnt_q >= CMAX);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    err_d   = err_q;
    wr_go   = 1'b0;
    if (!en) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (we.fall) begin
      armed_d = 1'b1;
      cnt_d   = CW'(1);
    end else if (armed_q && !we.lvl_n) begin
      if (!long_enough) cnt_d = cnt_q + CW'(1);
    end else if (armed_q && we.rise) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      if (long_enough) wr_go = 1'b1;
      else             err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign err = err_q;

  AST_WR_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !$past(we.lvl_n)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R8
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !wr_go); // R12
endmodule

// File: rtl/latram_ctrl.sv
module latram_ctrl
  import latram_pkg::*;
#(
  parameter int ADDR_W        = 6,
  parameter int DATA_W        = 4,
  parameter int MIN_WE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en_n,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              pulse_err
);
  logic    rst_sync_n;
  strobe_t me, we;
  logic    wr_go;
  logic    open_q, open_d;
  logic    oe_q, oe_d;
  logic    load;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] dout_q, dout_d, rd_data;

  latram_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));
  latram_strobe u_me (.clk(clk), .rst_n(rst_sync_n), .pin_n(mem_en_n), .strobe(me));
  latram_strobe u_we (.clk(clk), .rst_n(rst_sync_n), .pin_n(wr_en_n), .strobe(we));

  latram_wctl #(.MIN_WE_CYCLES(MIN_WE_CYCLES)) u_wctl (
    .clk(clk), .rst_n(rst_sync_n), .en(open_q & ~me.lvl_n), .we(we),
    .wr_go(wr_go), .err(pulse_err)
  );

  latram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_go), .wr_addr(addr_q),
    .wr_data(din), .rd_addr(addr_q), .rd_data(rd_data)
  );

  always_comb begin
    open_d = open_q;
    if (me.lvl_n)     open_d = 1'b0;
    else if (me.fall) open_d = 1'b1;
    addr_d = me.fall ? addr_in : addr_q;
    load   = open_q & ~me.lvl_n & we.lvl_n & ~we.rise;
    oe_d   = load;
    dout_d = load ? rd_data : dout_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      open_q <= 1'b0;
      addr_q <= '0;
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      open_q <= open_d;
      addr_q <= addr_d;
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign dout_oe = oe_q;
  assign dout    = oe_q ? dout_q : '0;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !me.fall |=> $stable(addr_q)); // R2
  AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    me.lvl_n |=> !dout_oe); // R7
  AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_q && !we.lvl_n) |=> !dout_oe); // R6
endmodule

// File: tb/latram_ctrl_bench.sv
module latram_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mem_en_n, wr_en_n;
  logic [5:0] addr_in;
  logic [3:0] din, dout;
  logic       dout_oe, pulse_err;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [3:0] first;

  // {addr, data} pairs
  localparam logic [9:0] VEC [8] = '{
    {6'd0,  4'hA}, {6'd63, 4'h5}, {6'd1,  4'hF}, {6'd32, 4'h0},
    {6'd17, 4'h3}, {6'd42, 4'hC}, {6'd7,  4'h9}, {6'd48, 4'h6}
  };

  always #4 clk = ~clk;

  latram_ctrl u_latram_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_en_n(mem_en_n), .wr_en_n(wr_en_n),
    .addr_in(addr_in), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pulse_err(pulse_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic open_at(input logic [5:0] a);
    @(negedge clk);
    addr_in = a;
    mem_en_n = 1'b0;
    repeat (4) @(negedge clk);
    addr_in = ~a;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_acc();
    @(negedge clk) mem_en_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] d, input int n);
    @(negedge clk);
    din = d;
    wr_en_n = 1'b0;
    repeat (n) @(negedge clk);
    wr_en_n = 1'b1;
    repeat (6) @(negedge clk);
    din = ~d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mem_en_n = 1'b1; wr_en_n = 1'b1; addr_in = '0; din = '0;
    do_reset();
    check("R1 oe", dout_oe, 0);
    check("R1 dout", dout, 0);
    check("R1 err", pulse_err, 0);

    // table: write every vector, then read all back
    for (int i = 0; i < 8; i++) begin
      open_at(VEC[i][9:4]);
      pulse(VEC[i][3:0], 4);
      close_acc();
    end
    for (int i = 0; i < 8; i++) begin
      open_at(VEC[i][9:4]);
      check("R3 oe", dout_oe, 1);
      check("R5 data", dout, VEC[i][3:0]);
      close_acc();
      check("R7 oe", dout_oe, 0);
    end
    check("R7 dout", dout, 0);

    // R2: address bus moves after capture
    open_at(6'd0);
    addr_in = 6'd63;
    repeat (4) @(negedge clk);
    check("R2 held read", dout, 4'hA);
    pulse(4'h2, 4);
    close_acc();
    open_at(6'd63);
    check("R2 other untouched", dout, 4'h5);
    close_acc();

    // R4: two reads return the same word
    open_at(6'd0);
    first = dout;
    close_acc();
    open_at(6'd0);
    check("R4 repeat", dout, first);
    check("R2 write to held", dout, 4'h2);

    // R6 / R11: in-access write
    @(negedge clk) din = 4'h7; wr_en_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 oe low", dout_oe, 0);
    wr_en_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R11 new data", dout, 4'h7);
    check("R11 oe", dout_oe, 1);
    close_acc();

    // R12: write strobe while disabled
    @(negedge clk) din = 4'h1; wr_en_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_en_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R12 err", pulse_err, 0);
    open_at(6'd0);
    check("R12 unchanged", dout, 4'h7);
    close_acc();

    // R8: short pulse rejected
    open_at(6'd1);
    pulse(4'h4, 2);
    check("R8 err", pulse_err, 1);
    check("R8 no write", dout, 4'hF);
    close_acc();

    // R9: pulse exactly at the limit
    open_at(6'd1);
    pulse(4'h8, 3);
    check("R9 write", dout, 4'h8);
    check("R8 sticky", pulse_err, 1);
    close_acc();

    // R10: reset keeps memory
    do_reset();
    check("R1 err cleared", pulse_err, 0);
    open_at(6'd63);
    check("R10 retained", dout, 4'h5);
    close_acc();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule